// File: doc/BRIEF.md
# Polarity- and Trigger-Configurable Interrupt Aggregator

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Lines 0 to 15 are internal sources. They are fixed as active-high and rising-edge. Lines from 16 upward are external. A build parameter sets how many exist, from 0 to 16. Each external line has its own build-time choice of active level and its own choice of edge or level triggering.

Every input is first converted to active-high. It then raises a sticky status bit, either on a rising edge or for as long as it is active. Status is ANDed with a software-written enable mask to form the pending bits, and the output is the OR of the pending bits. Software clears status bits through a write-only acknowledge register. A level source that is still active re-latches its bit at once, so a level interrupt stays asserted until its cause is removed.

The register port is a simple 32-bit select/write-enable bus. Only whole-word accesses are supported. Read data is registered, so it appears one cycle after the access.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, status, enable and the stored previous input of every line are zero, `irq_out` is low, and reads of status (0x30) and enable (0x38) return 0.
- R2: An external line configured active-low is treated as asserted when its input is 0. With rising-edge triggering, a 1-to-0 input transition sets its status bit.
- R3: On an edge-triggered line, a status bit is set only in the cycle the active-high input goes from 0 to 1. If the input is still held after an acknowledge, the bit is not set again.
- R4: On a level-triggered line, the status bit is set in every cycle the active-high input is 1. An acknowledge while the input is still active leaves the bit set. Once the input is inactive, an acknowledge clears it.
- R5: Lines 0 to 15 always behave as active-high and rising-edge, whatever the external parameters say.
- R6: The pending register (0x34, read-only) is status AND enable. `irq_out` is the OR of the pending bits and is registered. It changes at the same clock edge that updates status or enable, including the edge of an enable write to 0x38.
- R7: Writing 1 to a bit of the acknowledge register (0x3C) clears that status bit. Writing 0 leaves it unchanged. Reads of 0x3C return 0.
- R8: Bus writes to the status (0x30) or pending (0x34) addresses change nothing. Status bits are set only by input events.
- R9: If a new event arrives on a line in the same cycle that its status bit is acknowledged, the bit stays set.
- R10: Lines at or above 16 plus the number of external lines never set status. Their enable bits always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Raw interrupt lines; bit n is line n |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of a 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
Some internal faults show up at the ports only at the next register read. Examples are a stale previous-input flop, which fakes or hides an edge, and a wrong polarity inversion, which latches an idle line. Such a fault appears in the status word one cycle after the read strobe. A wrong status or enable bit that is also unmasked shows on `irq_out` at the very next clock edge. The directed scenarios therefore compare `irq_out` right after each input or write edge and read status or pending back right away. The acknowledge scenarios, with the input held, with the input released, and with a simultaneous event, expose a wrong ordering between clearing and re-latching within one read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned LINES     = 32;
  localparam int unsigned INT_LINES = 16;
  localparam int unsigned MAX_EXT   = 16;

  localparam logic [7:0] OFS_STATUS = 8'h30;
  localparam logic [7:0] OFS_PEND   = 8'h34;
  localparam logic [7:0] OFS_ENABLE = 8'h38;
  localparam logic [7:0] OFS_ACK    = 8'h3C;

  typedef logic [LINES-1:0] irq_vec_t;
endpackage

// File: rtl/irq_line_cond.sv
module irq_line_cond #(
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter bit EDGE_MODE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic evt,
  output logic held
);
  logic norm;
  logic prev_q;

  // convert to active-high before any detection
  assign norm = raw ^ ~ACTIVE_HIGH;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= norm;
  end

  if (EDGE_MODE) begin : g_edge
    assign evt  = norm & ~prev_q;
    assign held = 1'b0;

    // an edge event can never last two cycles
    assert_edge_single_R3: assert property (@(posedge clk) disable iff (rst)
      evt |=> !evt);
  end else begin : g_level
    assign evt  = norm;
    assign held = norm;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
#(
  parameter irq_vec_t IMPL_MASK = '1
) (
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t evt_vec,
  input  irq_vec_t held_vec,
  input  irq_vec_t ack_vec,
  input  logic     en_wr,
  input  irq_vec_t en_wdata,
  output irq_vec_t status_q,
  output irq_vec_t enable_q,
  output logic     irq_out
);
  irq_vec_t status_d;
  irq_vec_t enable_d;

  always_comb begin
    // ack clears first, new events set afterwards so they win
    status_d = ((status_q & ~ack_vec) | evt_vec) & IMPL_MASK;
    enable_d = en_wr ? (en_wdata & IMPL_MASK) : enable_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_out  <= 1'b0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq_out  <= |(status_d & enable_d);
    end
  end

  assert_out_tracks_pending_R6: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(status_q & enable_q));

  assert_level_relatch_R4: assert property (@(posedge clk) disable iff (rst)
    (held_vec != '0) |=> ((status_q & $past(held_vec)) == $past(held_vec)));

  assert_set_only_by_event_R8: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q) & ~$past(evt_vec)) == '0));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    ((status_q & $past(ack_vec & ~evt_vec)) == '0));

  assert_unused_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (((status_q | enable_q) & ~IMPL_MASK) == '0));
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  irq_vec_t          bus_wdata,
  input  irq_vec_t          status_q,
  input  irq_vec_t          enable_q,
  output logic              en_wr,
  output irq_vec_t          ack_vec,
  output irq_vec_t          bus_rdata
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);

  logic wr;
  logic rd;

  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign en_wr   = wr && (bus_addr == A_ENABLE);
  assign ack_vec = (wr && (bus_addr == A_ACK)) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      unique case (bus_addr)
        A_STATUS: bus_rdata <= status_q;
        A_PEND:   bus_rdata <= status_q & enable_q;
        A_ENABLE: bus_rdata <= enable_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned     NUM_EXT         = 16,
  parameter logic [15:0]     EXT_ACTIVE_HIGH = 16'hFFFF,
  parameter logic [15:0]     EXT_EDGE        = 16'hFFFF,
  parameter int unsigned     ADDR_W          = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       irq_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam int unsigned USED      = INT_LINES + NUM_EXT;
  localparam irq_vec_t    IMPL_MASK = irq_vec_t'((64'd1 << USED) - 64'd1);

  if (NUM_EXT > MAX_EXT) begin : g_bad_cfg
    $error("irq_aggregator: NUM_EXT above 16 is not supported");
  end

  irq_vec_t evt_vec;
  irq_vec_t held_vec;
  irq_vec_t ack_vec;
  irq_vec_t status_q;
  irq_vec_t enable_q;
  logic     en_wr;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (i < INT_LINES) begin : g_int
      irq_line_cond #(.ACTIVE_HIGH(1'b1), .EDGE_MODE(1'b1)) u_cond (
        .clk(clk), .rst(rst), .raw(irq_in[i]),
        .evt(evt_vec[i]), .held(held_vec[i]));
    end else if (i < USED) begin : g_ext
      irq_line_cond #(
        .ACTIVE_HIGH(EXT_ACTIVE_HIGH[i-INT_LINES]),
        .EDGE_MODE  (EXT_EDGE[i-INT_LINES])
      ) u_cond (
        .clk(clk), .rst(rst), .raw(irq_in[i]),
        .evt(evt_vec[i]), .held(held_vec[i]));
    end else begin : g_none
      assign evt_vec[i]  = 1'b0;
      assign held_vec[i] = 1'b0;
    end
  end

  irq_status_bank #(.IMPL_MASK(IMPL_MASK)) u_bank (
    .clk(clk), .rst(rst),
    .evt_vec(evt_vec), .held_vec(held_vec), .ack_vec(ack_vec),
    .en_wr(en_wr), .en_wdata(bus_wdata),
    .status_q(status_q), .enable_q(enable_q), .irq_out(irq_out));

  irq_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status_q(status_q), .enable_q(enable_q),
    .en_wr(en_wr), .ack_vec(ack_vec), .bus_rdata(bus_rdata));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_out && status_q == '0 && enable_q == '0));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ST = 8'h30, A_PD = 8'h34, A_EN = 8'h38, A_AK = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = 32'h000A_0000;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // ext line 16: high/edge, 17: low/edge, 18: high/level, 19: low/level
  irq_aggregator #(.NUM_EXT(8), .EXT_ACTIVE_HIGH(16'hFFF5),
                   .EXT_EDGE(16'hFFF3), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    tick();
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e,
                            input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  task automatic t_reset();
    chk(irq_out == 1'b0, "R1 irq_out", {31'b0, irq_out}, 32'h0);
    expect_reg(A_ST, 32'h0, "R1 status");
    expect_reg(A_EN, 32'h0, "R1 enable");
  endtask

  task automatic t_unused_lines();
    wr(A_EN, 32'hFFFF_FFFF);
    expect_reg(A_EN, 32'h00FF_FFFF, "R10 enable mask");
    irq_in[28] = 1'b1;
    tick();
    expect_reg(A_ST, 32'h0, "R10 unused line");
    chk(irq_out == 1'b0, "R10 irq_out", {31'b0, irq_out}, 32'h0);
    irq_in[28] = 1'b0;
  endtask

  task automatic t_internal_edge();
    irq_in[3] = 1'b1;
    tick();
    chk(irq_out == 1'b1, "R6 irq_out rises", {31'b0, irq_out}, 32'h1);
    expect_reg(A_ST, 32'h8, "R5 internal edge");
    wr(A_AK, 32'h8);
    chk(irq_out == 1'b0, "R3 irq_out after ack", {31'b0, irq_out}, 32'h0);
    expect_reg(A_ST, 32'h0, "R3 held edge not relatched");
    irq_in[3] = 1'b0;
    tick();
  endtask

  task automatic t_level();
    irq_in[18] = 1'b1;
    tick();
    expect_reg(A_ST, 32'h0004_0000, "R4 level set");
    wr(A_AK, 32'h0004_0000);
    expect_reg(A_ST, 32'h0004_0000, "R4 level relatch");
    chk(irq_out == 1'b1, "R4 irq_out held", {31'b0, irq_out}, 32'h1);
    irq_in[18] = 1'b0;
    tick();
    wr(A_AK, 32'h0004_0000);
    expect_reg(A_ST, 32'h0, "R4 level cleared");
    chk(irq_out == 1'b0, "R4 irq_out low", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_polarity();
    irq_in[17] = 1'b0;
    tick();
    expect_reg(A_ST, 32'h0002_0000, "R2 active-low edge");
    wr(A_AK, 32'h0002_0000);
    irq_in[17] = 1'b1;
    tick();
    expect_reg(A_ST, 32'h0, "R2 release no event");
    irq_in[19] = 1'b0;
    tick();
    wr(A_AK, 32'h0008_0000);
    expect_reg(A_ST, 32'h0008_0000, "R2 active-low level held");
    irq_in[19] = 1'b1;
    tick();
    wr(A_AK, 32'h0008_0000);
    expect_reg(A_ST, 32'h0, "R2 active-low level released");
  endtask

  task automatic t_pending();
    wr(A_EN, 32'h0001_0000);
    irq_in[5] = 1'b1;
    tick();
    irq_in[5] = 1'b0;
    chk(irq_out == 1'b0, "R6 masked", {31'b0, irq_out}, 32'h0);
    expect_reg(A_PD, 32'h0, "R6 pending masked");
    wr(A_EN, 32'h20);
    chk(irq_out == 1'b1, "R6 enable write same edge", {31'b0, irq_out}, 32'h1);
    expect_reg(A_PD, 32'h20, "R6 pending");
    wr(A_AK, 32'h0);
    expect_reg(A_ST, 32'h20, "R7 ack zero no effect");
    expect_reg(A_AK, 32'h0, "R7 ack reads zero");
    wr(A_ST, 32'hFFFF_FFFF);
    wr(A_PD, 32'hFFFF_FFFF);
    expect_reg(A_ST, 32'h20, "R8 status not writable");
    wr(A_AK, 32'h20);
    expect_reg(A_ST, 32'h0, "R7 ack clears");
    chk(irq_out == 1'b0, "R7 irq_out low", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_collide();
    wr(A_EN, 32'h80);
    irq_in[7] = 1'b1;
    tick();
    irq_in[7] = 1'b0;
    tick();
    irq_in[7] = 1'b1;
    wr(A_AK, 32'h80);
    expect_reg(A_ST, 32'h80, "R9 event beats ack");
    chk(irq_out == 1'b1, "R9 irq_out", {31'b0, irq_out}, 32'h1);
    wr(A_AK, 32'h80);
    expect_reg(A_ST, 32'h0, "R9 later ack clears");
    irq_in[7] = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_unused_lines();
    t_internal_edge();
    t_level();
    t_polarity();
    t_pending();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule